// File: doc/BRIEF.md
# Reconfigurable Region Isolation Controller

This block guards the boundary between the fixed part of a chip and a region whose logic is swapped at run time. Software drives it through a small two-register control port that is separate from the data path. One register holds two controls: an isolation switch and a reset for the swappable region. The other register is read-only and reports the live boundary state. While isolation is on, every signal that the region drives reaches the static side as a constant idle value. The signals sent into the region are also held idle. This keeps the static design working when the region holds no logic, or holds logic that is part-way through being reloaded.

Data words of 32 bits cross the boundary in both directions through small FIFOs. The interrupt request from the region also passes through the gate. To bring up new logic, software keeps isolation on, pulses the region reset, and only then opens the boundary. Teardown runs the same steps in reverse. The block rejects any control write that would open the boundary while the region is still in reset. It also stretches each software release of the reset by a fixed number of cycles.

Top module: `rr_isolation_ctrl`

## Requirements
- R1: After system reset, isolation is on, the region reset is asserted, both FIFOs are empty, the error flag is clear, the control register reads 3 and the status register reads 0x17.
- R2: While isolated, the region-driven inputs (interrupt, read-push, write-take) have no effect. `st_irq` and `st_rd_valid` stay 0, and the read FIFO stays empty.
- R3: While isolated, `rg_wr_valid`, `rg_wr_data` and `rg_rd_ready` are 0, and `st_wr_ready` is 0, so static-side pushes are dropped.
- R4: `rg_rst` follows control bit 1. After software clears that bit, `rg_rst` stays high for RST_HOLD (16) more cycles.
- R5: A control write that would leave bit 0 at 0 while the region reset is asserted is dropped whole. This covers bit 1 set in the same write, and the release hold still running. Such a write sets status bit 6, which stays set until system reset.
- R6: With isolation off, words pushed on the static write port appear at `rg_wr_valid`/`rg_wr_data` in order. The FIFO holds FIFO_DEPTH (4) words. When it is full, `st_wr_ready` is 0, a further push is lost, and status bit 3 is set.
- R7: With isolation off, words pushed by the region appear at `st_rd_valid`/`st_rd_data` in order.
- R8: Turning isolation on empties both FIFOs by the second cycle. No earlier word reaches the region after isolation is later turned off.
- R9: With isolation off, `rg_irq` is passed straight to `st_irq`.
- R10: Writes to the status register (address 1) change nothing.
- R11: Register address 0 is control: bit 0 is isolate (1 means forced idle) and bit 1 is region reset (1 means asserted). Address 1 is status: bit0 isolate, bit1 boundary reset, bit2 write FIFO empty, bit3 write FIFO full, bit4 read FIFO empty, bit5 read FIFO full, bit6 sequence error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 2 | Control write data (bit0 isolate, bit1 region reset) |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| st_wr_valid | input | 1 | Static side offers a word toward the region |
| st_wr_data | input | 32 | Word toward the region |
| st_wr_ready | output | 1 | Write FIFO accepts a word |
| st_rd_valid | output | 1 | A word from the region is available |
| st_rd_data | output | 32 | Word from the region |
| st_rd_take | input | 1 | Static side consumes the word |
| st_irq | output | 1 | Gated interrupt toward the static side |
| rg_rst | output | 1 | Reset into the region |
| rg_wr_valid | output | 1 | A word is available to the region |
| rg_wr_data | output | 32 | Word to the region |
| rg_wr_take | input | 1 | Region consumes the word |
| rg_rd_valid | input | 1 | Region offers a word |
| rg_rd_data | input | 32 | Word from the region |
| rg_rd_ready | output | 1 | Read FIFO accepts a region word |
| rg_irq | input | 1 | Interrupt request from the region |

## Verification
Most state in this block shows up at the ports within one clock. A wrong isolate bit shows up in the same cycle as a nonzero `rg_wr_valid`/`rg_rd_ready` or a live `st_irq`. A wrong hold counter moves the `rg_rst` falling edge away from exactly sixteen cycles after the release write. A missed flush is the slowest fault to see. It only appears once the boundary is reopened, as a stale word on `rg_wr_valid`, or before that as a clear empty bit in status. The error bit is checked for both ways a write can be refused.

// File: rtl/rr_iso_pkg.sv
package rr_iso_pkg;

    localparam int DATA_W = 32;
    localparam int CTRL_W = 2;

    localparam logic REG_CTRL = 1'b0;
    localparam logic REG_STAT = 1'b1;

    localparam int CTRL_ISO = 0;
    localparam int CTRL_RST = 1;

    // Signals driven by the region, as seen before and after the gate
    typedef struct packed {
        logic              wr_take;
        logic              rd_push;
        logic [DATA_W-1:0] rd_data;
        logic              irq;
    } from_region_t;

    // Signals driven into the region
    typedef struct packed {
        logic              wr_avail;
        logic [DATA_W-1:0] wr_data;
        logic              rd_room;
    } to_region_t;

    localparam from_region_t FROM_IDLE = '0;
    localparam to_region_t   TO_IDLE   = '0;

    typedef struct packed {
        logic wr_empty;
        logic wr_full;
        logic rd_empty;
        logic rd_full;
    } fifo_flags_t;

    // A write must never leave the boundary open while the region is in reset
    function automatic logic write_refused(input logic new_iso, input logic new_rst,
                                           input logic rst_busy);
        return !new_iso && (new_rst || rst_busy);
    endfunction

endpackage

// File: rtl/rr_iso_fifo.sv
module rr_iso_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4   // power of two, at least 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wptr, rptr, count;
    logic             do_push, do_pop;

    assign count   = wptr - rptr;
    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr[AW-1:0]] <= wdata;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);

    // R6
    push_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !flush) |=> !empty);

endmodule

// File: rtl/rr_iso_regs.sv
module rr_iso_regs
    import rr_iso_pkg::*;
#(
    parameter int RST_HOLD = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [CTRL_W-1:0] wdata,
    input  fifo_flags_t       flags,
    output logic [31:0]       rdata,
    output logic              iso_o,
    output logic              region_rst_o
);
    localparam int HOLD_W = $clog2(RST_HOLD + 1);

    logic              sw_iso, sw_rst, seq_err;
    logic [HOLD_W-1:0] hold_cnt;
    logic              busy, ctrl_wr, refused, accept;

    assign busy    = sw_rst || (hold_cnt != '0);
    assign ctrl_wr = wr_en && (addr == REG_CTRL);
    assign refused = ctrl_wr && write_refused(wdata[CTRL_ISO], wdata[CTRL_RST], busy);
    assign accept  = ctrl_wr && !refused;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_iso   <= 1'b1;
            sw_rst   <= 1'b1;
            seq_err  <= 1'b0;
            hold_cnt <= '0;
        end else begin
            if (accept) begin
                sw_iso <= wdata[CTRL_ISO];
                sw_rst <= wdata[CTRL_RST];
            end
            if (refused) seq_err <= 1'b1;

            if (accept && wdata[CTRL_RST])
                hold_cnt <= '0;
            else if (accept && sw_rst)
                hold_cnt <= HOLD_W'(RST_HOLD);
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign iso_o        = sw_iso;
    assign region_rst_o = busy;

    always_comb begin
        if (addr == REG_CTRL)
            rdata = {30'b0, sw_rst, sw_iso};
        else
            rdata = {25'b0, seq_err, flags.rd_full, flags.rd_empty,
                     flags.wr_full, flags.wr_empty, busy, sw_iso};
    end

    // R5
    iso_guard_chk: assert property (@(posedge clk) disable iff (rst)
        region_rst_o |-> iso_o);

    // R4
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_rst) |-> region_rst_o);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

endmodule

// File: rtl/rr_iso_gate.sv
module rr_iso_gate
    import rr_iso_pkg::*;
(
    input  logic         iso,
    input  from_region_t from_raw,
    input  to_region_t   to_raw,
    output from_region_t from_safe,
    output to_region_t   to_safe
);
    always_comb begin
        from_safe = iso ? FROM_IDLE : from_raw;
        to_safe   = iso ? TO_IDLE   : to_raw;
    end
endmodule

// File: rtl/rr_isolation_ctrl.sv
module rr_isolation_ctrl
    import rr_iso_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int RST_HOLD   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              st_wr_valid,
    input  logic [DATA_W-1:0] st_wr_data,
    output logic              st_wr_ready,
    output logic              st_rd_valid,
    output logic [DATA_W-1:0] st_rd_data,
    input  logic              st_rd_take,
    output logic              st_irq,
    output logic              rg_rst,
    output logic              rg_wr_valid,
    output logic [DATA_W-1:0] rg_wr_data,
    input  logic              rg_wr_take,
    input  logic              rg_rd_valid,
    input  logic [DATA_W-1:0] rg_rd_data,
    output logic              rg_rd_ready,
    input  logic              rg_irq
);
    logic              iso;
    fifo_flags_t       flags;
    from_region_t      from_raw, from_safe;
    to_region_t        to_raw, to_safe;
    logic [DATA_W-1:0] wf_head;
    logic              wf_push, wf_pop, rf_push, rf_pop;

    rr_iso_regs #(.RST_HOLD(RST_HOLD)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .flags(flags), .rdata(reg_rdata),
        .iso_o(iso), .region_rst_o(rg_rst)
    );

    assign from_raw = '{wr_take: rg_wr_take, rd_push: rg_rd_valid,
                        rd_data: rg_rd_data, irq: rg_irq};
    assign to_raw   = '{wr_avail: !flags.wr_empty, wr_data: wf_head,
                        rd_room: !flags.rd_full};

    rr_iso_gate u_gate (
        .iso(iso), .from_raw(from_raw), .to_raw(to_raw),
        .from_safe(from_safe), .to_safe(to_safe)
    );

    assign st_wr_ready = !flags.wr_full && !iso;
    assign wf_push     = st_wr_valid && st_wr_ready;
    assign wf_pop      = from_safe.wr_take && to_safe.wr_avail;

    rr_iso_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_wr_fifo (
        .clk(clk), .rst(rst), .flush(iso), .push(wf_push), .wdata(st_wr_data),
        .pop(wf_pop), .rdata(wf_head), .empty(flags.wr_empty), .full(flags.wr_full)
    );

    assign rf_push     = from_safe.rd_push && to_safe.rd_room;
    assign st_rd_valid = !flags.rd_empty && !iso;
    assign rf_pop      = st_rd_take && st_rd_valid;

    rr_iso_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rd_fifo (
        .clk(clk), .rst(rst), .flush(iso), .push(rf_push), .wdata(from_safe.rd_data),
        .pop(rf_pop), .rdata(st_rd_data), .empty(flags.rd_empty), .full(flags.rd_full)
    );

    assign st_irq      = from_safe.irq;
    assign rg_wr_valid = to_safe.wr_avail;
    assign rg_wr_data  = to_safe.wr_data;
    assign rg_rd_ready = to_safe.rd_room;

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(iso) |=> (flags.wr_empty && flags.rd_empty));

    // R3
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        iso |-> (!rg_wr_valid && !rg_rd_ready && !st_wr_ready));

    // R2
    idle_in_chk: assert property (@(posedge clk) disable iff (rst)
        iso |-> (!st_irq && !st_rd_valid));

endmodule

// File: tb/rr_isolation_ctrl_test.sv
module rr_isolation_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_addr = 1'b0;
    logic [1:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        st_wr_valid = 1'b0;
    logic [31:0] st_wr_data = '0;
    logic        st_wr_ready;
    logic        st_rd_valid;
    logic [31:0] st_rd_data;
    logic        st_rd_take = 1'b0;
    logic        st_irq;
    logic        rg_rst;
    logic        rg_wr_valid;
    logic [31:0] rg_wr_data;
    logic        rg_wr_take = 1'b0;
    logic        rg_rd_valid = 1'b0;
    logic [31:0] rg_rd_data = '0;
    logic        rg_rd_ready;
    logic        rg_irq = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rr_isolation_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .st_wr_valid(st_wr_valid), .st_wr_data(st_wr_data), .st_wr_ready(st_wr_ready),
        .st_rd_valid(st_rd_valid), .st_rd_data(st_rd_data), .st_rd_take(st_rd_take),
        .st_irq(st_irq), .rg_rst(rg_rst),
        .rg_wr_valid(rg_wr_valid), .rg_wr_data(rg_wr_data), .rg_wr_take(rg_wr_take),
        .rg_rd_valid(rg_rd_valid), .rg_rd_data(rg_rd_data), .rg_rd_ready(rg_rd_ready),
        .rg_irq(rg_irq)
    );

    // {write bits[1:0], gap cycles[7:0], expected control[1:0], expected error}
    localparam logic [12:0] TBL [7] = '{
        {2'b01, 8'd20, 2'b01, 1'b0},
        {2'b00, 8'd0,  2'b00, 1'b0},
        {2'b01, 8'd0,  2'b01, 1'b0},
        {2'b11, 8'd0,  2'b11, 1'b0},
        {2'b01, 8'd20, 2'b01, 1'b0},
        {2'b00, 8'd0,  2'b00, 1'b0},
        {2'b10, 8'd0,  2'b00, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic a, input logic [1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic st_push(input logic [31:0] d);
        @(negedge clk);
        st_wr_valid = 1'b1; st_wr_data = d;
        @(negedge clk);
        st_wr_valid = 1'b0;
    endtask

    task automatic rg_push(input logic [31:0] d);
        @(negedge clk);
        rg_rd_valid = 1'b1; rg_rd_data = d;
        @(negedge clk);
        rg_rd_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] exp_w [4];
        exp_w = '{32'h11, 32'h22, 32'h33, 32'h44};

        do_reset();

        // Control sequencing table (R4 R5 R11)
        for (int i = 0; i < 7; i++) begin
            reg_write(1'b0, TBL[i][12:11]);
            repeat (int'(TBL[i][10:3])) @(negedge clk);
            reg_read(1'b0, rv);
            chk("R11 table control", rv, {30'b0, TBL[i][2:1]});
            reg_read(1'b1, rv);
            chk("R5 table error bit", {31'b0, rv[6]}, {31'b0, TBL[i][0]});
        end

        // R1 reset state
        do_reset();
        reg_read(1'b0, rv); chk("R1 control", rv, 32'h3);
        reg_read(1'b1, rv); chk("R1 status", rv, 32'h17);
        chk("R1 rg_rst", {31'b0, rg_rst}, 32'h1);
        chk("R1 rg_wr_valid", {31'b0, rg_wr_valid}, 32'h0);

        // R10 status write ignored
        reg_write(1'b1, 2'b00);
        reg_read(1'b1, rv); chk("R10 status", rv, 32'h17);
        reg_read(1'b0, rv); chk("R10 control", rv, 32'h3);

        // R2 R3 isolated boundary
        @(negedge clk);
        rg_irq = 1'b1; rg_rd_valid = 1'b1; rg_rd_data = 32'hAA; st_wr_valid = 1'b1; st_wr_data = 32'hBB;
        rg_wr_take = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 st_irq", {31'b0, st_irq}, 32'h0);
        chk("R2 st_rd_valid", {31'b0, st_rd_valid}, 32'h0);
        chk("R3 rg_rd_ready", {31'b0, rg_rd_ready}, 32'h0);
        chk("R3 st_wr_ready", {31'b0, st_wr_ready}, 32'h0);
        chk("R3 rg_wr_data", rg_wr_data, 32'h0);
        reg_read(1'b1, rv); chk("R2 fifos untouched", rv, 32'h17);
        rg_irq = 1'b0; rg_rd_valid = 1'b0; st_wr_valid = 1'b0; rg_wr_take = 1'b0;

        // R4 release hold
        reg_write(1'b0, 2'b01);
        for (int k = 0; k < 16; k++) begin
            chk("R4 rg_rst held", {31'b0, rg_rst}, 32'h1);
            @(negedge clk);
        end
        chk("R4 rg_rst released", {31'b0, rg_rst}, 32'h0);

        reg_write(1'b0, 2'b00);
        reg_read(1'b0, rv); chk("R11 boundary open", rv, 32'h0);
        chk("R6 ready when open", {31'b0, st_wr_ready}, 32'h1);

        // R9 interrupt passes
        rg_irq = 1'b1; #1;
        chk("R9 st_irq", {31'b0, st_irq}, 32'h1);
        rg_irq = 1'b0;

        // R6 write path, fill and overflow
        for (int k = 0; k < 4; k++) st_push(exp_w[k]);
        chk("R6 full ready", {31'b0, st_wr_ready}, 32'h0);
        reg_read(1'b1, rv); chk("R6 full status", rv, 32'h18);
        st_push(32'h55);
        for (int k = 0; k < 4; k++) begin
            chk("R6 wr valid", {31'b0, rg_wr_valid}, 32'h1);
            chk("R6 wr order", rg_wr_data, exp_w[k]);
            rg_wr_take = 1'b1;
            @(negedge clk);
            rg_wr_take = 1'b0;
        end
        chk("R6 drained", {31'b0, rg_wr_valid}, 32'h0);

        // R7 read path
        rg_push(32'hA1);
        rg_push(32'hB2);
        chk("R7 rd valid", {31'b0, st_rd_valid}, 32'h1);
        chk("R7 first", st_rd_data, 32'hA1);
        st_rd_take = 1'b1; @(negedge clk); st_rd_take = 1'b0;
        chk("R7 second", st_rd_data, 32'hB2);
        st_rd_take = 1'b1; @(negedge clk); st_rd_take = 1'b0;
        chk("R7 drained", {31'b0, st_rd_valid}, 32'h0);

        // R8 flush on isolation
        st_push(32'h66);
        st_push(32'h77);
        reg_read(1'b1, rv); chk("R8 before isolate", rv, 32'h10);
        reg_write(1'b0, 2'b01);
        chk("R3 idle after isolate", {31'b0, rg_wr_valid}, 32'h0);
        @(negedge clk);
        reg_read(1'b1, rv); chk("R8 flushed", rv, 32'h15);
        reg_write(1'b0, 2'b00);
        chk("R8 nothing stale", {31'b0, rg_wr_valid}, 32'h0);

        // R5 refused writes
        reg_write(1'b0, 2'b10);
        reg_read(1'b0, rv); chk("R5 reset-while-open refused", rv, 32'h0);
        reg_read(1'b1, rv); chk("R5 error set", rv, 32'h54);
        chk("R5 rg_rst low", {31'b0, rg_rst}, 32'h0);
        reg_write(1'b0, 2'b01);
        reg_write(1'b0, 2'b11);
        reg_write(1'b0, 2'b01);
        reg_write(1'b0, 2'b00);
        reg_read(1'b0, rv); chk("R5 open during hold refused", rv, 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule